// File: doc/BRIEF.md
# Pipelined Complex Sample-by-Oscillator Multiplier

This block multiplies an IQ sample stream by a stream of cosine/sine pairs and emits one complex product per pair of inputs. Both inputs use valid/ready streaming handshakes. A transfer takes place only when both inputs present valid data in the same cycle and the pipeline can move. The sample's end-of-packet flag travels with the product.

Each sample lane is 24 bits wide. It carries a 21-bit signed value with 15 fractional bits, and the top three bits are sign padding. The oscillator word holds two 16-bit signed values with 14 fractional bits. The four real products and the add and subtract are exact at 38 bits. Each component is then cut to 32 bits by dropping its six least significant bits, which leaves 23 fractional bits. The pipeline is four register stages deep. The whole pipeline freezes while the output is valid and the consumer is not ready.

Top module: `cplx_stream_mul`

## Requirements
- R1: While rst_n is low (active-low reset) and after it is released, p_valid stays low until the first pair of operands is accepted.
- R2: a_ready is high only when b_valid is high, and b_ready is high only when a_valid is high. The two inputs therefore always transfer in the same cycle, and a lone valid input is never consumed.
- R3: In a_data the I lane is bits [23:0] and the Q lane is bits [47:24]. Only the low 21 bits of each lane are used, as a two's-complement value, so the three pad bits of a lane have no effect on the product.
- R4: In b_data the cosine is bits [15:0] and the sine is bits [31:16], both two's-complement.
- R5: The real part is I*cos - Q*sin and the imaginary part is I*sin + Q*cos, both computed exactly at 38-bit signed precision.
- R6: p_data bits [31:0] hold the real part and bits [63:32] the imaginary part. Each is the 38-bit result shifted right arithmetically by 6 (floor truncation).
- R7: p_last equals the a_last that was accepted with the same sample.
- R8: A pair accepted in cycle n appears with p_valid high in cycle n+4 when p_ready stays high.
- R9: While p_valid is high and p_ready is low, p_data and p_last hold steady, p_valid stays high and no input pair is accepted.
- R10: Exactly one product leaves for each accepted pair, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_data | input | 48 | Sample operand: Q lane high, I lane low |
| a_last | input | 1 | End-of-packet flag of the sample |
| a_valid | input | 1 | Sample operand valid |
| a_ready | output | 1 | Sample operand accepted this cycle when valid |
| b_data | input | 32 | Oscillator operand: sine high, cosine low |
| b_valid | input | 1 | Oscillator operand valid |
| b_ready | output | 1 | Oscillator operand accepted this cycle when valid |
| p_data | output | 64 | Product: imaginary high, real low |
| p_last | output | 1 | End-of-packet flag of the product |
| p_valid | output | 1 | Product valid |
| p_ready | input | 1 | Consumer ready |

## Verification
Assertions check four properties on every cycle: the two inputs transfer only together, nothing is accepted while the output is stalled, and p_valid, p_data and p_last hold through a stall. The bench scenarios cover what the assertions cannot. These are the arithmetic itself, including extreme operands, the floor rounding of small negative results and ignored pad bits, the exact four-cycle latency, and the packet flag. They also show that every accepted pair comes out exactly once and in order after a long stall.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
   // Fixed number of register stages from acceptance to output
   localparam int unsigned CMUL_STAGES = 4;

   // Control tag carried alongside the data in each stage
   typedef struct packed {
      logic vld;
      logic last;
   } cmul_tag_t;
endpackage

// File: rtl/cmul_join.sv
module cmul_join (
   input  logic a_valid,
   input  logic b_valid,
   input  logic adv,
   output logic a_ready,
   output logic b_ready,
   output logic fire
);
   // Each side is offered ready only when its partner is also valid
   assign a_ready = b_valid & adv;
   assign b_ready = a_valid & adv;
   assign fire    = a_valid & b_valid & adv;
endmodule

// File: rtl/cmul_ctrl_pipe.sv
module cmul_ctrl_pipe
   import cmul_pkg::*;
#(
   parameter int unsigned STAGES = CMUL_STAGES
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic in_last,
   input  logic out_ready,
   output logic adv,
   output logic out_valid,
   output logic out_last
);
   cmul_tag_t tag_q [STAGES];

   // Global stall: only a valid, unaccepted head blocks the pipe
   assign adv = ~tag_q[STAGES-1].vld | out_ready;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  tag_q[0] <= '0;
               end else if (adv) begin
                  tag_q[0].vld  <= fire;
                  tag_q[0].last <= fire & in_last;
               end
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  tag_q[s] <= '0;
               end else if (adv) begin
                  tag_q[s] <= tag_q[s-1];
               end
            end
         end
      end
   endgenerate

   assign out_valid = tag_q[STAGES-1].vld;
   assign out_last  = tag_q[STAGES-1].last;

   AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_last))) else
      $error("valid or last dropped during stall"); // R9
endmodule

// File: rtl/cmul_datapath.sv
module cmul_datapath #(
   parameter int unsigned LANE_W  = 24,
   parameter int unsigned A_VAL_W = 21,
   parameter int unsigned B_W     = 16,
   parameter int unsigned DROP    = 6,
   localparam int unsigned PROD_W = A_VAL_W + B_W,
   localparam int unsigned FULL_W = PROD_W + 1,
   localparam int unsigned OUT_W  = FULL_W - DROP
) (
   input  logic                  clk,
   input  logic                  adv,
   input  logic [2*LANE_W-1:0]   a_data,
   input  logic [2*B_W-1:0]      b_data,
   output logic [2*OUT_W-1:0]    p_data
);
   // Lane 0 = in-phase / cosine, lane 1 = quadrature / sine
   logic signed [A_VAL_W-1:0] a_lane [2];
   logic signed [B_W-1:0]     b_lane [2];

   generate
      for (genvar l = 0; l < 2; l++) begin : g_unpack
         // Pad bits above A_VAL_W are discarded; sign comes from bit A_VAL_W-1
         assign a_lane[l] = $signed(a_data[l*LANE_W +: A_VAL_W]);
         assign b_lane[l] = $signed(b_data[l*B_W +: B_W]);
      end
   endgenerate

   // Stage 1: operand capture
   logic signed [A_VAL_W-1:0] s1_i, s1_q;
   logic signed [B_W-1:0]     s1_c, s1_s;
   // Stage 2: four partial products
   logic signed [PROD_W-1:0]  s2_ic, s2_qs, s2_is, s2_qc;
   // Stage 3: full-precision sums
   logic signed [FULL_W-1:0]  s3_re, s3_im;
   // Stage 4: truncated output
   logic [OUT_W-1:0]          s4_re, s4_im;

   always_ff @(posedge clk) begin
      if (adv) begin
         s1_i  <= a_lane[0];
         s1_q  <= a_lane[1];
         s1_c  <= b_lane[0];
         s1_s  <= b_lane[1];
         s2_ic <= PROD_W'(s1_i) * PROD_W'(s1_c);
         s2_qs <= PROD_W'(s1_q) * PROD_W'(s1_s);
         s2_is <= PROD_W'(s1_i) * PROD_W'(s1_s);
         s2_qc <= PROD_W'(s1_q) * PROD_W'(s1_c);
         s3_re <= FULL_W'(s2_ic) - FULL_W'(s2_qs);
         s3_im <= FULL_W'(s2_is) + FULL_W'(s2_qc);
         s4_re <= s3_re[FULL_W-1:DROP];
         s4_im <= s3_im[FULL_W-1:DROP];
      end
   end

   assign p_data = {s4_im, s4_re};
endmodule

// File: rtl/cplx_stream_mul.sv
module cplx_stream_mul
   import cmul_pkg::*;
#(
   parameter int unsigned LANE_W  = 24,
   parameter int unsigned A_VAL_W = 21,
   parameter int unsigned B_W     = 16,
   parameter int unsigned DROP    = 6,
   parameter int unsigned OUT_W   = 32,
   localparam int unsigned FULL_W = A_VAL_W + B_W + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2*LANE_W-1:0] a_data,
   input  logic                a_last,
   input  logic                a_valid,
   output logic                a_ready,
   input  logic [2*B_W-1:0]    b_data,
   input  logic                b_valid,
   output logic                b_ready,
   output logic [2*OUT_W-1:0]  p_data,
   output logic                p_last,
   output logic                p_valid,
   input  logic                p_ready
);
   generate
      if (A_VAL_W > LANE_W) begin : g_bad_lane
         $error("A_VAL_W must fit inside LANE_W");
      end
      if (FULL_W - DROP != OUT_W) begin : g_bad_out
         $error("OUT_W must equal the full product width minus DROP");
      end
      if (DROP >= FULL_W) begin : g_bad_drop
         $error("DROP must be smaller than the full product width");
      end
   endgenerate

   logic adv, fire;

   cmul_join u_join (
      .a_valid (a_valid),
      .b_valid (b_valid),
      .adv     (adv),
      .a_ready (a_ready),
      .b_ready (b_ready),
      .fire    (fire)
   );

   cmul_ctrl_pipe #(.STAGES(CMUL_STAGES)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire),
      .in_last   (a_last),
      .out_ready (p_ready),
      .adv       (adv),
      .out_valid (p_valid),
      .out_last  (p_last)
   );

   cmul_datapath #(
      .LANE_W  (LANE_W),
      .A_VAL_W (A_VAL_W),
      .B_W     (B_W),
      .DROP    (DROP)
   ) u_dp (
      .clk    (clk),
      .adv    (adv),
      .a_data (a_data),
      .b_data (b_data),
      .p_data (p_data)
   );

   AST_PAIRED_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      (a_valid && a_ready) |-> (b_valid && b_ready)) else
      $error("sample accepted without oscillator word"); // R2

   AST_STALL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (p_valid && !p_ready) |-> !(a_ready || b_ready)) else
      $error("input accepted during output stall"); // R9

   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (p_valid && !p_ready) |=> $stable(p_data)) else
      $error("output data changed during stall"); // R9
endmodule

// File: tb/cplx_stream_mul_test.sv
module cplx_stream_mul_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [47:0] a_data;
   logic        a_last, a_valid, a_ready;
   logic [31:0] b_data;
   logic        b_valid, b_ready;
   logic [63:0] p_data;
   logic        p_last, p_valid, p_ready;

   int checks = 0;
   int fails  = 0;
   int out_cnt = 0;
   bit done = 1'b0;
   logic [64:0] expq[$];

   always #5 clk = ~clk;

   cplx_stream_mul uut (
      .clk(clk), .rst_n(rst_n),
      .a_data(a_data), .a_last(a_last), .a_valid(a_valid), .a_ready(a_ready),
      .b_data(b_data), .b_valid(b_valid), .b_ready(b_ready),
      .p_data(p_data), .p_last(p_last), .p_valid(p_valid), .p_ready(p_ready)
   );

   // Stimulus table: pad bits in several lanes are deliberately non-sign (R3)
   localparam int NV = 8;
   localparam logic [47:0] TA [NV] = '{
      48'h000000_000400, 48'hF00000_0FFFFF, 48'h3FFFFD_E00003, 48'h000001_FFFFFF,
      48'hFABCDE_012345, 48'hA00000_600000, 48'hF00000_F00000, 48'hFFFFF9_000005};
   localparam logic [31:0] TB [NV] = '{
      32'h0000_4000, 32'h8000_7FFF, 32'hEDCB_1234, 32'h4000_C000,
      32'hD2BF_2D41, 32'h7FFF_7FFF, 32'h8000_8000, 32'hFFFE_0003};
   localparam logic [NV-1:0] TL = 8'b1001_0110;

   // Reference from R3..R6: signed lanes, exact sums, floor shift by 6
   function automatic logic [63:0] ref_prod(logic [47:0] a, logic [31:0] b);
      longint i, q, c, s, re, im;
      i  = longint'($signed(a[20:0]));
      q  = longint'($signed(a[44:24]));
      c  = longint'($signed(b[15:0]));
      s  = longint'($signed(b[31:16]));
      re = (i * c - q * s) >>> 6;
      im = (i * s + q * c) >>> 6;
      return {im[31:0], re[31:0]};
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   // Scoreboard monitor: samples settled values between edges
   always begin
      @(negedge clk);
      #1;
      if (rst_n === 1'b1) begin
         if (a_valid && a_ready)
            expq.push_back({a_last, ref_prod(a_data, b_data)});
         if (p_valid && p_ready) begin
            out_cnt++;
            if (expq.size() == 0) begin
               chk("R10 unexpected product", 64'(out_cnt), 64'd0);
            end else begin
               logic [64:0] e;
               e = expq.pop_front();
               chk("R3 R4 R5 R6 product data", p_data, e[63:0]);
               chk("R7 last flag", 64'(p_last), 64'(e[64]));
            end
         end
      end
   end

   task automatic send(logic [47:0] a, logic [31:0] b, logic l);
      @(negedge clk);
      a_data = a; b_data = b; a_last = l; a_valid = 1'b1; b_valid = 1'b1;
      #1;
      while (!a_ready) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      a_valid = 1'b0; b_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; a_data = '0; b_data = '0; a_last = 1'b0;
      a_valid = 1'b0; b_valid = 1'b0; p_ready = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", 64'(p_valid), 64'd0);
      chk("R2 readies idle in reset", 64'({a_ready, b_ready}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1 valid after reset", 64'(p_valid), 64'd0);

      // Table walk, back-to-back, consumer always ready
      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         a_data = TA[k]; b_data = TB[k]; a_last = TL[k];
         a_valid = 1'b1; b_valid = 1'b1;
         #1;
         chk("R2 ready with both valid", 64'({a_ready, b_ready}), 64'b11);
      end
      @(negedge clk);
      a_valid = 1'b0; b_valid = 1'b0;
      repeat (8) @(negedge clk);
      #2;
      chk("R10 table drained", 64'(expq.size()), 64'd0);
      chk("R10 table count", 64'(out_cnt), 64'(NV));

      // Latency: one pair, p_valid only in the fourth cycle after acceptance
      @(negedge clk);
      a_data = TA[4]; b_data = TB[4]; a_last = 1'b1; a_valid = 1'b1; b_valid = 1'b1;
      @(negedge clk);
      a_valid = 1'b0; b_valid = 1'b0;
      #2;
      chk("R8 cycle n+1", 64'(p_valid), 64'd0);
      @(negedge clk); #2;
      chk("R8 cycle n+2", 64'(p_valid), 64'd0);
      @(negedge clk); #2;
      chk("R8 cycle n+3", 64'(p_valid), 64'd0);
      @(negedge clk); #2;
      chk("R8 cycle n+4", 64'(p_valid), 64'd1);
      @(negedge clk); #2;
      chk("R8 single beat", 64'(p_valid), 64'd0);

      // Lone valid inputs are never consumed
      @(negedge clk);
      a_data = TA[1]; b_data = TB[1]; a_valid = 1'b1; b_valid = 1'b0;
      for (int k = 0; k < 4; k++) begin
         #1;
         chk("R2 lone sample not ready", 64'(a_ready), 64'd0);
         @(negedge clk);
      end
      a_valid = 1'b0; b_valid = 1'b1;
      for (int k = 0; k < 4; k++) begin
         #1;
         chk("R2 lone osc not ready", 64'(b_ready), 64'd0);
         @(negedge clk);
      end
      b_valid = 1'b0;
      repeat (6) @(negedge clk);
      #2;
      chk("R2 nothing emitted from lone valids", 64'(out_cnt), 64'(NV + 1));

      // Backpressure: stall with a full pipe, then drain in order
      p_ready = 1'b0;
      fork
         begin
            for (int k = 1; k < 7; k++) send(TA[k], TB[k], TL[k]);
         end
      join_none
      repeat (8) @(negedge clk);
      #2;
      begin
         logic [63:0] held;
         logic        held_last;
         held = p_data;
         held_last = p_last;
         chk("R9 valid while stalled", 64'(p_valid), 64'd1);
         for (int k = 0; k < 3; k++) begin
            @(negedge clk); #2;
            chk("R9 data held", p_data, held);
            chk("R9 last held", 64'(p_last), 64'(held_last));
            chk("R9 no accept in stall", 64'({a_ready, b_ready}), 64'd0);
         end
      end
      @(negedge clk);
      p_ready = 1'b1;
      repeat (14) @(negedge clk);
      #2;
      chk("R10 stall drained", 64'(expq.size()), 64'd0);
      chk("R10 total count", 64'(out_cnt), 64'(NV + 7));
      finish_run();
   end
endmodule